// File: doc/BRIEF.md
# Transmit-Side L0s Idle Controller

This block governs the transmit direction of one serial link under autonomous low-power control. It watches a packet-pending level and counts consecutive cycles in which nothing is waiting to be sent. When the low-power enable bit of a two-bit control field is set and the idle run reaches a programmable threshold, the block requests one electrical-idle ordered set. After the downstream logic acknowledges that request, the block holds the transmitter in electrical idle. The receive direction is never touched.

The block leaves low power when traffic arrives or when software clears the enable bit. A minimum hold time in electrical idle always applies first. On exit it wakes the transmitter and asks for a burst of fast training sequences so the far receiver can regain bit and symbol lock. The burst length is sampled from an 8-bit input at the moment exit begins. Each sequence is requested with a level that stays high until the serializer acknowledges it. Serialization, the receive side and the deeper two-sided low-power handshake are outside this block.

The controller has four states: ACTIVE (code 0), ENTER (code 1), IDLE (code 2) and WAKE (code 3). Its transitions are:
- ACTIVE→ENTER when the idle run is long enough.
- ENTER→IDLE on acknowledge of the idle ordered set.
- IDLE→WAKE once the hold has elapsed and either traffic is pending or the enable bit is clear.
- WAKE→ACTIVE once the sequence count is exhausted.

Top module: `txl0s_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `link_state` is 0, `eios_req` and `fts_req` are 0 and `elec_idle` is 0.
- R2: In ACTIVE, an idle counter starts from 0. It counts each cycle with `pkt_pending` low and `pm_ctrl[0]` high, and is cleared by any cycle with `pkt_pending` high or `pm_ctrl[0]` low. ACTIVE→ENTER happens on the edge after the counter has reached `idle_limit`, with `pkt_pending` low and `pm_ctrl[0]` high in that cycle. With limit L, the state becomes 1 after L+1 idle edges.
- R3: Entry depends only on `pm_ctrl[0]`. Encodings 00 and 10 never leave ACTIVE, and `pm_ctrl[1]` has no effect.
- R4: In ENTER, `eios_req` is held high until a cycle with `os_ack` high. The next state is IDLE, in which `elec_idle` is 1.
- R5: `pkt_pending` rising during ENTER does not abort entry. The block stays in ENTER until the acknowledge and then goes to IDLE.
- R6: The block stays in IDLE for at least MIN_HOLD+1 cycles. With pending traffic present from entry, IDLE→WAKE happens on the (MIN_HOLD+1)-th edge after IDLE was entered.
- R7: `fts_num` is sampled on the IDLE→WAKE edge. In WAKE, `fts_req` is high while sequences remain, and each cycle with `os_ack` high consumes one. When none remain, the next edge returns to ACTIVE; a count of 0 returns after one WAKE cycle with no request.
- R8: With `pm_ctrl[0]` cleared in IDLE, the block goes to WAKE as soon as the hold has elapsed, even with no pending traffic.
- R9: `link_state` encodes ACTIVE=0, ENTER=1, IDLE=2, WAKE=3. `eios_req` is high only in ENTER, `fts_req` only in WAKE, and `elec_idle` only in IDLE.
- R10: After a return to ACTIVE, the idle counter starts again from 0, so a full `idle_limit` run is needed before the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_pending | input | 1 | High while a transaction or link packet waits to be sent |
| pm_ctrl | input | 2 | Low-power control; bit 0 enables autonomous entry, bit 1 unused here |
| idle_limit | input | IDLE_W | Idle cycles required before entry |
| fts_num | input | 8 | Number of fast training sequences to send on exit |
| os_ack | input | 1 | Acknowledge of the current ordered-set request |
| eios_req | output | 1 | Request for one electrical-idle ordered set |
| fts_req | output | 1 | Request for one fast training sequence |
| elec_idle | output | 1 | Transmitter held in electrical idle |
| link_state | output | 2 | Current state code |

## Verification
The hardest situation to reach from the ports is a wake-up request that lands inside the minimum hold window or during the entry handshake. Reaching it needs a long idle run, a withheld acknowledge and traffic arriving within a narrow window afterwards. Directed sequences build each case explicitly: traffic during ENTER, traffic already present on entry into IDLE, and a cleared enable with no traffic. Directed sequences also change `fts_num` right after exit starts. Random phases then use short thresholds, bursty traffic densities and randomly withheld acknowledges, so entry, hold and exit overlap in many orders, all compared each cycle with a bench reference.

// File: rtl/txl0s_pkg.sv
package txl0s_pkg;
    typedef enum logic [1:0] {
        LS_ACTIVE = 2'd0,
        LS_ENTER  = 2'd1,
        LS_IDLE   = 2'd2,
        LS_WAKE   = 2'd3
    } lstate_t;
endpackage

// File: rtl/txl0s_idle_timer.sv
module txl0s_idle_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count,
    input  logic [W-1:0] limit,
    output logic         reached
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!count)
            cnt_q <= '0;
        else if (cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q >= limit);
endmodule

// File: rtl/txl0s_hold_timer.sv
module txl0s_hold_timer #(
    parameter int MIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int HW = $clog2(MIN_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(MIN_CYC);
    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != HMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == HMAX);
endmodule

// File: rtl/txl0s_fts_counter.sv
module txl0s_fts_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         empty
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign empty = (left_q == '0);
endmodule

// File: rtl/txl0s_ctrl.sv
module txl0s_ctrl
    import txl0s_pkg::*;
#(
    parameter int IDLE_W   = 11,
    parameter int MIN_HOLD = 16,
    parameter int FTS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_pending,
    input  logic [1:0]        pm_ctrl,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [FTS_W-1:0]  fts_num,
    input  logic              os_ack,
    output logic              eios_req,
    output logic              fts_req,
    output logic              elec_idle,
    output logic [1:0]        link_state
);
    lstate_t state_q, state_d;

    logic idle_count, idle_reached;
    logic hold_done;
    logic fts_load, fts_dec, fts_empty;
    logic wake_cause;
    logic unused_pm_hi;

    assign unused_pm_hi = pm_ctrl[1];

    // Idle run only grows in ACTIVE with entry enabled and nothing queued
    assign idle_count = (state_q == LS_ACTIVE) && pm_ctrl[0] && !pkt_pending;
    assign wake_cause = pkt_pending || !pm_ctrl[0];
    assign fts_load   = (state_q == LS_IDLE) && hold_done && wake_cause;
    assign fts_dec    = (state_q == LS_WAKE) && os_ack;

    txl0s_idle_timer #(.W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (idle_count),
        .limit   (idle_limit),
        .reached (idle_reached)
    );

    txl0s_hold_timer #(.MIN_CYC(MIN_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == LS_IDLE),
        .done  (hold_done)
    );

    txl0s_fts_counter #(.W(FTS_W)) u_fts (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fts_load),
        .load_val (fts_num),
        .dec      (fts_dec),
        .empty    (fts_empty)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LS_ACTIVE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_ACTIVE: if (idle_count && idle_reached) state_d = LS_ENTER;
            LS_ENTER:  if (os_ack)                     state_d = LS_IDLE;
            LS_IDLE:   if (hold_done && wake_cause)    state_d = LS_WAKE;
            LS_WAKE:   if (fts_empty)                  state_d = LS_ACTIVE;
            default:                                   state_d = LS_ACTIVE;
        endcase
    end

    // Outputs, decoded from the registered state
    always_comb begin
        eios_req  = 1'b0;
        fts_req   = 1'b0;
        elec_idle = 1'b0;
        unique case (state_q)
            LS_ACTIVE: ;
            LS_ENTER:  eios_req  = 1'b1;
            LS_IDLE:   elec_idle = 1'b1;
            LS_WAKE:   fts_req   = !fts_empty;
            default:   ;
        endcase
        link_state = state_q;
    end
endmodule

// File: rtl/txl0s_checker.sv
module txl0s_checker #(
    parameter int MIN_HOLD = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pm_ctrl,
    input logic       os_ack,
    input logic       eios_req,
    input logic       fts_req,
    input logic       elec_idle,
    input logic [1:0] link_state
);
    logic [15:0] ei_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ei_run <= '0;
        else if (!elec_idle)
            ei_run <= '0;
        else if (ei_run != 16'hFFFF)
            ei_run <= ei_run + 1'b1;
    end

    p_no_entry_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd0 && !pm_ctrl[0]) |=> link_state == 2'd0);

    p_idle_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elec_idle) |-> $past(eios_req && os_ack));

    p_eios_in_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eios_req |-> link_state == 2'd1);

    p_fts_in_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fts_req |-> link_state == 2'd3);

    p_min_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(elec_idle) |-> (ei_run > 16'(MIN_HOLD) && link_state == 2'd3));

    p_enter_from_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd1 && $past(link_state) != 2'd1) |-> $past(link_state) == 2'd0);
endmodule

bind txl0s_ctrl txl0s_checker #(.MIN_HOLD(MIN_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pm_ctrl    (pm_ctrl),
    .os_ack     (os_ack),
    .eios_req   (eios_req),
    .fts_req    (fts_req),
    .elec_idle  (elec_idle),
    .link_state (link_state)
);

// File: tb/txl0s_ctrl_bench.sv
`timescale 1ns/1ps
module txl0s_ctrl_bench;
    localparam int IDLE_W   = 11;
    localparam int MIN_HOLD = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_pending = 1'b0;
    logic [1:0]        pm_ctrl = 2'b00;
    logic [IDLE_W-1:0] idle_limit = 11'd4;
    logic [7:0]        fts_num = 8'd0;
    logic              os_ack = 1'b0;
    logic              eios_req, fts_req, elec_idle;
    logic [1:0]        link_state;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    txl0s_ctrl #(.IDLE_W(IDLE_W), .MIN_HOLD(MIN_HOLD), .FTS_W(8)) u_txl0s_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_pending(pkt_pending), .pm_ctrl(pm_ctrl),
        .idle_limit(idle_limit), .fts_num(fts_num), .os_ack(os_ack),
        .eios_req(eios_req), .fts_req(fts_req), .elec_idle(elec_idle),
        .link_state(link_state)
    );

    // Bench reference model, written from the requirements
    int m_state = 0;
    int m_idle  = 0;
    int m_hold  = 0;
    int m_fts   = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_idle <= 0; m_hold <= 0; m_fts <= 0;
        end else begin
            m_idle <= (m_state == 0 && pm_ctrl[0] && !pkt_pending) ?
                      ((m_idle < 2047) ? m_idle + 1 : m_idle) : 0;
            m_hold <= (m_state == 2) ? ((m_hold < MIN_HOLD) ? m_hold + 1 : m_hold) : 0;
            case (m_state)
                0: if (pm_ctrl[0] && !pkt_pending && m_idle >= int'(idle_limit)) m_state <= 1;
                1: if (os_ack) m_state <= 2;
                2: if (m_hold == MIN_HOLD && (pkt_pending || !pm_ctrl[0])) begin
                       m_state <= 3; m_fts <= int'(fts_num);
                   end
                default: begin
                    if (m_fts == 0) m_state <= 0;
                    else if (os_ack) m_fts <= m_fts - 1;
                end
            endcase
        end
    end

    function automatic string tag_of(int st);
        case (st)
            0: return "R2";
            1: return "R4";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model (R9 encodings)
    always @(negedge clk) begin
        if (rst_n) begin
            check({tag_of(m_state), "/R9 state"}, int'(link_state), m_state);
            check("R4/R9 eios_req", int'(eios_req), int'(m_state == 1));
            check("R6/R9 elec_idle", int'(elec_idle), int'(m_state == 2));
            check("R7/R9 fts_req", int'(fts_req), int'(m_state == 3 && m_fts != 0));
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    int fts_seen;
    int dens;

    initial begin
        void'($urandom(32'd20240));
        step(3);
        check("R1 reset state", int'(link_state), 0);
        check("R1 reset req", int'({eios_req, fts_req, elec_idle}), 0);
        rst_n = 1'b1;
        step(1);
        check("R1 after reset", int'(link_state), 0);

        // R3: encodings 00 and 10 never enter
        step(30);
        check("R3 ctrl 00 stays active", int'(link_state), 0);
        pm_ctrl = 2'b10;
        step(30);
        check("R3 ctrl 10 stays active", int'(link_state), 0);

        // R2: limit 4 -> entry after five idle edges
        pm_ctrl = 2'b01;
        step(4);
        check("R2 before threshold", int'(link_state), 0);
        step(1);
        check("R2 entry", int'(link_state), 1);

        // R5: traffic during ENTER does not abort
        pkt_pending = 1'b1;
        step(5);
        check("R5 held in enter", int'(link_state), 1);
        check("R5 eios held", int'(eios_req), 1);
        os_ack = 1'b1;
        step(1);
        os_ack = 1'b0;
        check("R4 idle after ack", int'(link_state), 2);
        check("R4 elec_idle", int'(elec_idle), 1);

        // R6: minimum hold, then R7 sampling of fts_num
        fts_num = 8'd3;
        step(MIN_HOLD);
        check("R6 still held", int'(link_state), 2);
        step(1);
        check("R6 exit after hold", int'(link_state), 3);
        fts_num = 8'd7;
        os_ack = 1'b1;
        fts_seen = 0;
        for (int k = 0; k < 50 && link_state == 2'd3; k++) begin
            if (fts_req) fts_seen++;
            step(1);
        end
        os_ack = 1'b0;
        check("R7 fts count sampled", fts_seen, 3);
        check("R7 back to active", int'(link_state), 0);

        // R10: full threshold needed again
        pkt_pending = 1'b0;
        step(4);
        check("R10 no early re-entry", int'(link_state), 0);
        step(1);
        check("R10 re-entry", int'(link_state), 1);

        // R8: cleared enable forces exit once hold is met; R7 zero count
        os_ack = 1'b1;
        step(1);
        os_ack = 1'b0;
        pm_ctrl = 2'b00;
        fts_num = 8'd0;
        step(MIN_HOLD + 1);
        check("R8 forced exit", int'(link_state), 3);
        check("R7 zero count no request", int'(fts_req), 0);
        step(1);
        check("R7 zero count returns", int'(link_state), 0);

        // R2: pending clears the idle run
        pm_ctrl = 2'b11;
        idle_limit = 11'd6;
        step(4);
        pkt_pending = 1'b1;
        step(1);
        pkt_pending = 1'b0;
        step(6);
        check("R2 run restarted", int'(link_state), 0);
        step(1);
        check("R2 entry after restart", int'(link_state), 1);

        // Random phase, compared each cycle by the model
        dens = 30;
        for (int i = 0; i < 20000; i++) begin
            if (i % 500 == 0) begin
                case ($urandom % 3)
                    0: dens = 3;
                    1: dens = 30;
                    default: dens = 90;
                endcase
            end
            if (i % 200 == 0) idle_limit = 11'($urandom % 20);
            if (i % 300 == 0) begin
                case ($urandom % 8)
                    6: pm_ctrl = 2'b00;
                    7: pm_ctrl = 2'b10;
                    5: pm_ctrl = 2'b11;
                    default: pm_ctrl = 2'b01;
                endcase
            end
            pkt_pending = (($urandom % 100) < dens);
            os_ack      = $urandom % 2;
            fts_num     = 8'($urandom % 6);
            step(1);
        end
        report();
    end
endmodule